// File: doc/BRIEF.md
# Platform Reset Sequencer

This block drives one active-low reset line for the devices on a platform. Three conditions pull the line low: the initial power-up after the suspend-domain reset lets go, a loss of the core power-good indication, and a hard-reset command that software writes to a reset-control I/O port. The line is released only when power-good is high and synchronized, and a minimum-width window has run to its end since the last cause of reset.

The window is measured in ticks from a parameterized prescaler. The default is one tick per millisecond at 50 MHz, so a window of one tick meets the one-millisecond minimum for the software path. A simulation can shrink both numbers. While power-good is low, the window is held at its full length. A reset caused by power-good therefore ends only after power-good has been high for a whole window. A software trigger that arrives while a window is running starts the count again.

Top module: `plat_rst_seq`

## Requirements
- R1: While `resumeRstN` is low, `platRstN` is low at once, without waiting for a clock edge. Releasing `resumeRstN` starts the power-up sequence from its initial state.
- R2: If `pwrGoodAsync` is already high when `resumeRstN` is released, `platRstN` goes high on the (TICK_DIV*MIN_TICKS + SYNC_STAGES + 1)th rising clock edge after the release.
- R3: A write strobe (`ioWrite`=1) with `ioAddr` equal to CTRL_ADDR (default 16'h0CF9) and data bit TRIG_BIT (default bit 2) set drives `platRstN` low on the next rising edge.
- R4: A single software trigger with power-good high keeps `platRstN` low for exactly TICK_DIV*MIN_TICKS + 1 clock cycles. No reset pulse from any source is shorter than TICK_DIV*MIN_TICKS cycles.
- R5: A second valid trigger that arrives N cycles after the first, while the output is still low, restarts the window. The pulse then lasts N + TICK_DIV*MIN_TICKS + 1 cycles.
- R6: `pwrGoodAsync` goes through SYNC_STAGES flip-flops. When it falls, `platRstN` is low after the (SYNC_STAGES+1)th rising edge.
- R7: After power-good returns, `platRstN` rises only once power-good has been seen high for a full window. If power-good is sampled low on L consecutive edges, the low pulse lasts L + TICK_DIV*MIN_TICKS cycles, so a one-cycle glitch still yields a full-width pulse.
- R8: A write to any address other than CTRL_ADDR, or a write to CTRL_ADDR with bit TRIG_BIT clear, leaves `platRstN` unchanged.
- R9: `platRstN` comes straight from a flip-flop and changes only on a clock edge or on the assertion of `resumeRstN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock of the suspend domain |
| resumeRstN | input | 1 | Asynchronous active-low reset of the suspend domain |
| pwrGoodAsync | input | 1 | Core power-good; asynchronous to `clk` |
| ioAddr | input | ADDR_W | I/O write address |
| ioData | input | DATA_W | I/O write data |
| ioWrite | input | 1 | One-cycle write strobe |
| platRstN | output | 1 | Registered active-low platform reset |

## Verification
The assertions check four things on every cycle. The output is low whenever the suspend reset is held. A valid software write pulls the output low on the next edge. Power-good that has been low for three samples forces the output low. Every rising edge of the output comes after at least a full window of low cycles and after power-good has been seen high. The exact widths can only be shown by the scenarios the bench runs. Those widths are: the power-up delay, the single and restarted software pulses, and the glitch and long power-good pulses. The scenarios also show that writes with the wrong address or with the trigger bit clear leave the output high.

// File: rtl/plat_rst_pkg.sv
package plat_rst_pkg;

  // Strobes from the sequencing control into the datapath
  typedef struct packed {
    logic timerLoad;   // restart the minimum-width window
    logic releaseOut;  // value the output register takes (1 = released)
  } seqCtl_t;

  typedef enum logic [0:0] {
    SEQ_HOLD = 1'b0,
    SEQ_RUN  = 1'b1
  } seqState_t;

endpackage

// File: rtl/rst_pgood_sync.sv
module rst_pgood_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= 1'b0;
        else       stage <= asyncIn;
      end
      assign syncOut = stage;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
      assign syncOut = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rst_seq_datapath.sv
module rst_seq_datapath
  import plat_rst_pkg::*;
#(
  parameter int TICK_DIV    = 50000,
  parameter int MIN_TICKS   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pwrGoodAsync,
  input  seqCtl_t ctl,
  output logic    pgSync,
  output logic    timerDone,
  output logic    platRstN
);

  localparam int PRESC_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int REM_W   = $clog2(MIN_TICKS + 1) > 0 ? $clog2(MIN_TICKS + 1) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(TICK_DIV - 1);
  localparam logic [REM_W-1:0]   REM_FULL   = REM_W'(MIN_TICKS);

  logic [PRESC_W-1:0] prescCnt;
  logic [REM_W-1:0]   ticksLeft;
  logic               tickNow;
  logic               outReg;

  rst_pgood_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pwrGoodAsync),
    .syncOut (pgSync)
  );

  assign tickNow   = (prescCnt == PRESC_LAST);
  assign timerDone = (ticksLeft == '0);

  // Prescaler and window counter; a load restarts both so that the
  // window length does not depend on the tick phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt  <= '0;
      ticksLeft <= REM_FULL;
    end else if (ctl.timerLoad) begin
      prescCnt  <= '0;
      ticksLeft <= REM_FULL;
    end else if (!timerDone) begin
      if (tickNow) begin
        prescCnt  <= '0;
        ticksLeft <= ticksLeft - 1'b1;
      end else begin
        prescCnt  <= prescCnt + 1'b1;
      end
    end
  end

  // Output flop: the only driver of the platform reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= 1'b0;
    else       outReg <= ctl.releaseOut;
  end

  assign platRstN = outReg;

endmodule

// File: rtl/rst_seq_control.sv
module rst_seq_control
  import plat_rst_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0CF9,
  parameter int              TRIG_BIT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic              ioWrite,
  input  logic              pgSync,
  input  logic              timerDone,
  output seqCtl_t           ctl
);

  seqState_t state, nextState;
  logic      swReq;
  logic      holdCause;
  logic      unusedData;

  assign unusedData = ^ioData;

  always_comb begin
    swReq     = ioWrite && (ioAddr == CTRL_ADDR) && ioData[TRIG_BIT];
    holdCause = swReq || !pgSync;
    nextState = state;
    unique case (state)
      SEQ_HOLD: if (!holdCause && timerDone) nextState = SEQ_RUN;
      SEQ_RUN:  if (holdCause)               nextState = SEQ_HOLD;
      default:                               nextState = SEQ_HOLD;
    endcase
    ctl.timerLoad  = holdCause;
    ctl.releaseOut = (nextState == SEQ_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_HOLD;
    else       state <= nextState;
  end

endmodule

// File: rtl/plat_rst_seq.sv
module plat_rst_seq
  import plat_rst_pkg::*;
#(
  parameter int                TICK_DIV    = 50000,
  parameter int                MIN_TICKS   = 1,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'h0CF9,
  parameter int                TRIG_BIT    = 2
) (
  input  logic              clk,
  input  logic              resumeRstN,
  input  logic              pwrGoodAsync,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic              ioWrite,
  output logic              platRstN
);

  seqCtl_t seqCtl;
  logic    pgSync;
  logic    timerDone;

  rst_seq_control #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR),
    .TRIG_BIT  (TRIG_BIT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (resumeRstN),
    .ioAddr    (ioAddr),
    .ioData    (ioData),
    .ioWrite   (ioWrite),
    .pgSync    (pgSync),
    .timerDone (timerDone),
    .ctl       (seqCtl)
  );

  rst_seq_datapath #(
    .TICK_DIV    (TICK_DIV),
    .MIN_TICKS   (MIN_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (resumeRstN),
    .pwrGoodAsync (pwrGoodAsync),
    .ctl          (seqCtl),
    .pgSync       (pgSync),
    .timerDone    (timerDone),
    .platRstN     (platRstN)
  );

endmodule

// File: rtl/rst_seq_checker.sv
module rst_seq_checker #(
  parameter int                TICK_DIV  = 50000,
  parameter int                MIN_TICKS = 1,
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0CF9,
  parameter int                TRIG_BIT  = 2
) (
  input logic              clk,
  input logic              resumeRstN,
  input logic              pwrGoodAsync,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [DATA_W-1:0] ioData,
  input logic              ioWrite,
  input logic              platRstN
);

  localparam int MIN_LOW = TICK_DIV * MIN_TICKS;

  int unsigned lowRun;

  always_ff @(posedge clk or negedge resumeRstN) begin
    if (!resumeRstN)                lowRun <= 0;
    else if (!platRstN) begin
      if (lowRun < 32'hFFFF_FFF0)   lowRun <= lowRun + 1;
    end else                        lowRun <= 0;
  end

  // R1
  rst_held_low_chk: assert property (@(posedge clk)
    !resumeRstN |-> !platRstN);

  // R3
  sw_trigger_chk: assert property (@(posedge clk) disable iff (!resumeRstN)
    (ioWrite && ioAddr == CTRL_ADDR && ioData[TRIG_BIT]) |=> !platRstN);

  // R6
  pg_loss_chk: assert property (@(posedge clk) disable iff (!resumeRstN)
    (!pwrGoodAsync && !$past(pwrGoodAsync) && !$past(pwrGoodAsync, 2)) |=> !platRstN);

  // R4
  min_width_chk: assert property (@(posedge clk) disable iff (!resumeRstN)
    $rose(platRstN) |-> (lowRun >= MIN_LOW));

  // R7
  release_pg_chk: assert property (@(posedge clk) disable iff (!resumeRstN)
    $rose(platRstN) |-> ($past(pwrGoodAsync, 3) && $past(pwrGoodAsync, 4)));

endmodule

bind plat_rst_seq rst_seq_checker #(
  .TICK_DIV  (TICK_DIV),
  .MIN_TICKS (MIN_TICKS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .CTRL_ADDR (CTRL_ADDR),
  .TRIG_BIT  (TRIG_BIT)
) u_chk (
  .clk          (clk),
  .resumeRstN   (resumeRstN),
  .pwrGoodAsync (pwrGoodAsync),
  .ioAddr       (ioAddr),
  .ioData       (ioData),
  .ioWrite      (ioWrite),
  .platRstN     (platRstN)
);

// File: tb/plat_rst_seq_test.sv
`timescale 1ns/1ps
module plat_rst_seq_test;

  localparam int TICK_DIV  = 8;
  localparam int MIN_TICKS = 4;
  localparam int SYNC      = 2;
  localparam int WIN       = TICK_DIV * MIN_TICKS;
  localparam logic [15:0] CTRL = 16'h0CF9;

  typedef struct {
    int    width;
    string tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        resumeRstN = 1'b1;
  logic        pwrGoodAsync = 1'b1;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioData = '0;
  logic        ioWrite = 1'b0;
  logic        platRstN;

  int       checks = 0;
  int       errors = 0;
  int       lowCnt = 0;
  int       cycles = 0;
  bit       done = 0;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  plat_rst_seq #(
    .TICK_DIV    (TICK_DIV),
    .MIN_TICKS   (MIN_TICKS),
    .SYNC_STAGES (SYNC)
  ) uut (
    .clk          (clk),
    .resumeRstN   (resumeRstN),
    .pwrGoodAsync (pwrGoodAsync),
    .ioAddr       (ioAddr),
    .ioData       (ioData),
    .ioWrite      (ioWrite),
    .platRstN     (platRstN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expectPulse(input int w, input string tag);
    expItem_t it;
    it.width = w;
    it.tag   = tag;
    expQ.push_back(it);
  endtask

  task automatic writeIo(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr  = a;
    ioData  = d;
    ioWrite = 1'b1;
    @(negedge clk);
    ioWrite = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor: measures every low pulse and compares against the queue
  always @(negedge clk) begin
    if (!resumeRstN) begin
      lowCnt = 0;
    end else if (platRstN === 1'b0) begin
      lowCnt++;
    end else if (lowCnt > 0) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected reset pulse", lowCnt, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(lowCnt == it.width, it.tag, lowCnt, it.width);
      end
      lowCnt = 0;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      check(1'b0, "watchdog expired", cycles, 20000);
      finishRun();
    end
  end

  initial begin
    #1 resumeRstN = 1'b0;
    #4;
    // R1: reset state
    check(platRstN === 1'b0, "R1 reset state low", platRstN, 0);
    repeat (3) @(negedge clk);

    // R2: power-up with power-good already high
    expectPulse(WIN + SYNC, "R2 power-up width");
    #5 resumeRstN = 1'b1;
    repeat (50) @(negedge clk);
    check(platRstN === 1'b1, "R2 released after power-up", platRstN, 1);

    // R3/R4: single software trigger
    expectPulse(WIN + 1, "R4 software pulse width");
    writeIo(CTRL, 8'h04);
    repeat (50) @(negedge clk);
    check(platRstN === 1'b1, "R3 released after software pulse", platRstN, 1);

    // R5: retrigger 10 cycles later
    expectPulse(WIN + 11, "R5 restarted pulse width");
    writeIo(CTRL, 8'h04);
    repeat (8) @(negedge clk);
    writeIo(CTRL, 8'h06);
    repeat (60) @(negedge clk);

    // R8: wrong address, then trigger bit clear
    writeIo(16'h0CF8, 8'h04);
    repeat (5) @(negedge clk);
    check(platRstN === 1'b1, "R8 other address ignored", platRstN, 1);
    writeIo(CTRL, 8'h0A);
    repeat (5) @(negedge clk);
    check(platRstN === 1'b1, "R8 trigger bit clear ignored", platRstN, 1);

    // R7: one-cycle power-good glitch gives a full pulse
    expectPulse(1 + WIN, "R7 glitch pulse width");
    @(negedge clk) pwrGoodAsync = 1'b0;
    @(negedge clk) pwrGoodAsync = 1'b1;
    repeat (50) @(negedge clk);

    // R6/R7: long power-good loss
    expectPulse(20 + WIN, "R7 long loss pulse width");
    @(negedge clk) pwrGoodAsync = 1'b0;
    repeat (3) @(negedge clk);
    check(platRstN === 1'b0, "R6 low after sync delay", platRstN, 0);
    repeat (17) @(negedge clk);
    pwrGoodAsync = 1'b1;
    repeat (70) @(negedge clk);

    // R1: asynchronous resume reset mid-run
    @(negedge clk);
    #5 resumeRstN = 1'b0;
    #1 check(platRstN === 1'b0, "R1 async assertion", platRstN, 0);
    expectPulse(WIN + SYNC, "R1 restart after resume reset");
    repeat (3) @(negedge clk);
    #5 resumeRstN = 1'b1;
    repeat (50) @(negedge clk);
    check(platRstN === 1'b1, "R9 stable high at end", platRstN, 1);

    check(expQ.size() == 0, "R4 all expected pulses seen", expQ.size(), 0);
    finishRun();
  end

endmodule